// File: doc/BRIEF.md
# Dual-Width Carry and Overflow Adder

This block is the integer add/subtract slice of a 64-bit fixed-point unit. Each cycle it forms one sum from two operands under a 3-bit operation code and drives the full-width result combinationally. From that single addition it derives two carries (out of the low word and out of the whole word) and two signed-overflow indications (for the low word and for the whole word). A mode bit picks which pair feeds the mode-dependent flags. The low-word pair always feeds the fixed 32-bit flags.

The flags live in a five-bit status register: sticky summary overflow, overflow, 32-bit overflow, carry and 32-bit carry. An arithmetic write strobe commits flags from the current operation. A carry-recording enable gates the carry pair and an overflow enable gates the overflow trio. A separate status write port loads all five flags at once, which is how software sets or clears them. The extended operations take the stored carry as their carry-in, so multi-word arithmetic chains through the register.

Top module: `xadd_unit`

## Requirements
- R1: `result_o` is combinationally x + y + cin (modulo 2^XLEN). The terms depend on `op_i`. 0 add: a, b, 0. 1 subtract-from: ~a, b, 1. 2 extended add: a, b, CA. 3 extended subtract-from: ~a, b, CA. 4 add-minus-one: a, all ones, CA. 5 add-zero: a, 0, CA. 6 negate: ~a, 0, 1. 7 acts as code 0.
- R2: On a write with `ca_en_i` high and an op other than negate, CA32 takes the carry out of the low half-word. CA takes the carry out of the full word when `mode64_i`=1, and the low half-word carry when `mode64_i`=0.
- R3: On a write with `oe_i` high, OV32 takes the signed overflow of the low half-word. OV takes the full-word signed overflow when `mode64_i`=1, and the low half-word overflow when `mode64_i`=0. With `oe_i` low, OV and OV32 keep their values.
- R4: SO is set whenever OV is written as 1. It is otherwise kept, and only the status write port or reset can clear it.
- R5: The extended, add-minus-one and add-zero operations use the registered CA flag as the carry-in.
- R6: For negate with `oe_i` high, OV32 is written with the same value as OV. The operand's most negative value therefore sets both OV and OV32: the full-word value in 64-bit mode, or the low half-word value in 32-bit mode, where the upper half is ignored.
- R7: `sr_wr_i` loads the flags from `sr_wdata_i` with bit 4=SO, 3=OV, 2=OV32, 1=CA, 0=CA32. It takes priority over an arithmetic write in the same cycle.
- R8: Synchronous active-high reset clears all flags. With `wr_en_i` and `sr_wr_i` both low, no flag changes.
- R9: Negate never changes CA or CA32, even with `ca_en_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| mode64_i | input | 1 | 1 = full-width mode, 0 = half-width mode |
| oe_i | input | 1 | Overflow recording enable |
| ca_en_i | input | 1 | Carry recording enable |
| wr_en_i | input | 1 | Commit arithmetic flags this cycle |
| a_i | input | XLEN | First operand |
| b_i | input | XLEN | Second operand |
| sr_wr_i | input | 1 | Status register load strobe |
| sr_wdata_i | input | 5 | Status register load value |
| result_o | output | XLEN | Sum |
| so_o | output | 1 | Sticky summary overflow |
| ov_o | output | 1 | Mode-selected overflow |
| ov32_o | output | 1 | Half-word overflow |
| ca_o | output | 1 | Mode-selected carry |
| ca32_o | output | 1 | Half-word carry |

## Verification
The arithmetic flag commit and the status-register load can land in the same cycle. The sweep raises `sr_wr_i` on a fixed subset of operand pairs while `wr_en_i` is usually also high, and directed vectors pair an overflowing operation with a load of zero. The bench judges each collision by checking that the flags on the next cycle equal the loaded value and show no trace of the sum's carry or overflow. The sticky SO is checked across that boundary as well.

// File: rtl/xadd_pkg.sv
`timescale 1ns/1ps
package xadd_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUBF  = 3'd1,
        OP_ADDE  = 3'd2,
        OP_SUBFE = 3'd3,
        OP_ADDME = 3'd4,
        OP_ADDZE = 3'd5,
        OP_NEG   = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        BSRC_OPND = 2'd0,
        BSRC_ONES = 2'd1,
        BSRC_ZERO = 2'd2
    } bsrc_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } cin_e;

    typedef struct packed {
        logic  inv_a;
        bsrc_e bsrc;
        cin_e  cin;
        logic  rec_ca;
        logic  neg;
    } ctl_t;

    typedef struct packed {
        logic so;
        logic ov;
        logic ov32;
        logic ca;
        logic ca32;
    } flags_t;

    typedef struct packed {
        logic c_lo;
        logic c_full;
        logic v_lo;
        logic v_full;
    } arith_st_t;

    function automatic ctl_t decode_op(op_e op);
        ctl_t c;
        c.inv_a  = 1'b0;
        c.bsrc   = BSRC_OPND;
        c.cin    = CIN_ZERO;
        c.rec_ca = 1'b1;
        c.neg    = 1'b0;
        unique case (op)
            OP_SUBF:  begin c.inv_a = 1'b1; c.cin = CIN_ONE;  end
            OP_ADDE:  begin c.cin = CIN_FLAG; end
            OP_SUBFE: begin c.inv_a = 1'b1; c.cin = CIN_FLAG; end
            OP_ADDME: begin c.bsrc = BSRC_ONES; c.cin = CIN_FLAG; end
            OP_ADDZE: begin c.bsrc = BSRC_ZERO; c.cin = CIN_FLAG; end
            OP_NEG:   begin
                c.inv_a  = 1'b1;
                c.bsrc   = BSRC_ZERO;
                c.cin    = CIN_ONE;
                c.rec_ca = 1'b0;
                c.neg    = 1'b1;
            end
            default:  ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xadd_operand_mux.sv
`timescale 1ns/1ps
module xadd_operand_mux
    import xadd_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  ctl_t         ctl_i,
    input  logic         ca_q_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o,
    output logic         cin_o
);
    always_comb begin
        x_o = ctl_i.inv_a ? ~a_i : a_i;
        unique case (ctl_i.bsrc)
            BSRC_ONES: y_o = '1;
            BSRC_ZERO: y_o = '0;
            default:   y_o = b_i;
        endcase
        unique case (ctl_i.cin)
            CIN_ONE:  cin_o = 1'b1;
            CIN_FLAG: cin_o = ca_q_i;
            default:  cin_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xadd_seg_adder.sv
`timescale 1ns/1ps
module xadd_seg_adder
    import xadd_pkg::*;
#(
    parameter int W    = 64,
    parameter int SEGS = 2
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output arith_st_t    st_o
);
    localparam int SW = W / SEGS;

    logic [SEGS:0]   carry;
    logic [SEGS-1:0] sovf;

    assign carry[0] = cin_i;

    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        logic [SW:0] part;
        assign part = {1'b0, x_i[g*SW +: SW]} + {1'b0, y_i[g*SW +: SW]}
                    + {{SW{1'b0}}, carry[g]};
        assign sum_o[g*SW +: SW] = part[SW-1:0];
        assign carry[g+1] = part[SW];
        assign sovf[g] = (x_i[(g+1)*SW-1] == y_i[(g+1)*SW-1])
                      && (part[SW-1] != x_i[(g+1)*SW-1]);
    end

    always_comb begin
        st_o.c_lo   = carry[SEGS/2];
        st_o.c_full = carry[SEGS];
        st_o.v_lo   = sovf[SEGS/2-1];
        st_o.v_full = sovf[SEGS-1];
    end
endmodule

// File: rtl/xadd_status_reg.sv
`timescale 1ns/1ps
module xadd_status_reg
    import xadd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en_i,
    input  logic      ca_en_i,
    input  logic      oe_i,
    input  logic      mode64_i,
    input  ctl_t      ctl_i,
    input  arith_st_t st_i,
    input  logic      sr_wr_i,
    input  flags_t    sr_wdata_i,
    output flags_t    q_o
);
    logic ov_sel;
    logic ca_sel;

    always_comb begin
        ov_sel = mode64_i ? st_i.v_full : st_i.v_lo;
        ca_sel = mode64_i ? st_i.c_full : st_i.c_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (sr_wr_i) begin
            q_o <= sr_wdata_i;
        end else if (wr_en_i) begin
            if (ca_en_i && ctl_i.rec_ca) begin
                q_o.ca   <= ca_sel;
                q_o.ca32 <= st_i.c_lo;
            end
            if (oe_i) begin
                q_o.ov   <= ov_sel;
                q_o.ov32 <= ctl_i.neg ? ov_sel : st_i.v_lo;
                q_o.so   <= q_o.so | ov_sel;
            end
        end
    end
endmodule

// File: rtl/xadd_unit.sv
`timescale 1ns/1ps
module xadd_unit
    import xadd_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      op_i,
    input  logic            mode64_i,
    input  logic            oe_i,
    input  logic            ca_en_i,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sr_wr_i,
    input  logic [4:0]      sr_wdata_i,
    output logic [XLEN-1:0] result_o,
    output logic            so_o,
    output logic            ov_o,
    output logic            ov32_o,
    output logic            ca_o,
    output logic            ca32_o
);
    localparam int SEGS = 2;

    ctl_t            ctl;
    logic [XLEN-1:0] x;
    logic [XLEN-1:0] y;
    logic            cin;
    arith_st_t       st;
    flags_t          flags_q;

    assign ctl = decode_op(op_e'(op_i));

    xadd_operand_mux #(.W(XLEN)) u_opnd (
        .a_i    (a_i),
        .b_i    (b_i),
        .ctl_i  (ctl),
        .ca_q_i (flags_q.ca),
        .x_o    (x),
        .y_o    (y),
        .cin_o  (cin)
    );

    xadd_seg_adder #(.W(XLEN), .SEGS(SEGS)) u_add (
        .x_i   (x),
        .y_i   (y),
        .cin_i (cin),
        .sum_o (result_o),
        .st_o  (st)
    );

    xadd_status_reg u_sr (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .ca_en_i    (ca_en_i),
        .oe_i       (oe_i),
        .mode64_i   (mode64_i),
        .ctl_i      (ctl),
        .st_i       (st),
        .sr_wr_i    (sr_wr_i),
        .sr_wdata_i (flags_t'(sr_wdata_i)),
        .q_o        (flags_q)
    );

    assign so_o   = flags_q.so;
    assign ov_o   = flags_q.ov;
    assign ov32_o = flags_q.ov32;
    assign ca_o   = flags_q.ca;
    assign ca32_o = flags_q.ca32;
endmodule

// File: rtl/xadd_unit_chk.sv
`timescale 1ns/1ps
module xadd_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op_i,
    input logic       mode64_i,
    input logic       oe_i,
    input logic       ca_en_i,
    input logic       wr_en_i,
    input logic       sr_wr_i,
    input logic [4:0] sr_wdata_i,
    input logic       so_o,
    input logic       ov_o,
    input logic       ov32_o,
    input logic       ca_o,
    input logic       ca32_o
);
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> ({so_o, ov_o, ov32_o, ca_o, ca32_o} == 5'd0));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !sr_wr_i) |=>
            ($stable(so_o) && $stable(ov_o) && $stable(ov32_o)
             && $stable(ca_o) && $stable(ca32_o)));

    a_r7_sr_load: assert property (@(posedge clk) disable iff (rst)
        sr_wr_i |=> ({so_o, ov_o, ov32_o, ca_o, ca32_o} == $past(sr_wdata_i)));

    a_r4_so_sticky: assert property (@(posedge clk) disable iff (rst)
        (so_o && !sr_wr_i) |=> so_o);

    a_r4_so_follows_ov: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && oe_i && !sr_wr_i) |=> (!ov_o || so_o));

    a_r3_ov_keep: assert property (@(posedge clk) disable iff (rst)
        (!oe_i && !sr_wr_i) |=> ($stable(ov_o) && $stable(ov32_o)));

    a_r3_ov_half_mode: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && oe_i && !sr_wr_i && !mode64_i) |=> (ov_o == ov32_o));

    a_r2_ca_half_mode: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && ca_en_i && op_i != 3'd6 && !sr_wr_i && !mode64_i)
            |=> (ca_o == ca32_o));

    a_r9_neg_keeps_ca: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && op_i == 3'd6 && !sr_wr_i) |=> ($stable(ca_o) && $stable(ca32_o)));
endmodule

bind xadd_unit xadd_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .mode64_i   (mode64_i),
    .oe_i       (oe_i),
    .ca_en_i    (ca_en_i),
    .wr_en_i    (wr_en_i),
    .sr_wr_i    (sr_wr_i),
    .sr_wdata_i (sr_wdata_i),
    .so_o       (so_o),
    .ov_o       (ov_o),
    .ov32_o     (ov32_o),
    .ca_o       (ca_o),
    .ca32_o     (ca32_o)
);

// File: tb/xadd_unit_tb.sv
`timescale 1ns/1ps
module xadd_unit_tb;
    localparam int N  = 8;
    localparam int WW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [2:0]   op = 3'd0;
    logic         mode64 = 1'b0, oe = 1'b0, ca_en = 1'b0, wr = 1'b0, srwr = 1'b0;
    logic [N-1:0] a = '0, b = '0;
    logic [4:0]   srdata = '0;
    logic [N-1:0] res;
    logic         so, ov, ov32, ca, ca32;

    logic [2:0]    w_op = 3'd0;
    logic          w_mode = 1'b0, w_oe = 1'b0, w_caen = 1'b0, w_wr = 1'b0, w_srwr = 1'b0;
    logic [WW-1:0] w_a = '0, w_b = '0;
    logic [4:0]    w_srdata = '0;
    logic [WW-1:0] w_res;
    logic          w_so, w_ov, w_ov32, w_ca, w_ca32;

    xadd_unit #(.XLEN(N)) u_dut (
        .clk(clk), .rst(rst), .op_i(op), .mode64_i(mode64), .oe_i(oe),
        .ca_en_i(ca_en), .wr_en_i(wr), .a_i(a), .b_i(b), .sr_wr_i(srwr),
        .sr_wdata_i(srdata), .result_o(res), .so_o(so), .ov_o(ov),
        .ov32_o(ov32), .ca_o(ca), .ca32_o(ca32)
    );

    xadd_unit #(.XLEN(WW)) u_dut_wide (
        .clk(clk), .rst(rst), .op_i(w_op), .mode64_i(w_mode), .oe_i(w_oe),
        .ca_en_i(w_caen), .wr_en_i(w_wr), .a_i(w_a), .b_i(w_b), .sr_wr_i(w_srwr),
        .sr_wdata_i(w_srdata), .result_o(w_res), .so_o(w_so), .ov_o(w_ov),
        .ov32_o(w_ov32), .ca_o(w_ca), .ca32_o(w_ca32)
    );

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    // bench model of the small instance's flags
    bit  m_so = 0, m_ov = 0, m_ov32 = 0, m_ca = 0, m_ca32 = 0;

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic int sgn(int v, int bits);
        return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
    endfunction

    // one vector on the small instance: starts and ends at a falling edge
    task automatic step(input logic [2:0] o, input int av, input int bv,
                        input bit md, input bit oen, input bit cen,
                        input bit w, input bit sw, input logic [4:0] sd);
        int x, y, cin, full, lo, sfull, slo;
        bit c_full, c_lo, v_full, v_lo, vsel;
        string rtag;
        op = o; a = av[N-1:0]; b = bv[N-1:0]; mode64 = md; oe = oen;
        ca_en = cen; wr = w; srwr = sw; srdata = sd;
        case (o)
            3'd1: begin x = 255 - av; y = bv;  cin = 1;    end
            3'd2: begin x = av;       y = bv;  cin = m_ca; end
            3'd3: begin x = 255 - av; y = bv;  cin = m_ca; end
            3'd4: begin x = av;       y = 255; cin = m_ca; end
            3'd5: begin x = av;       y = 0;   cin = m_ca; end
            3'd6: begin x = 255 - av; y = 0;   cin = 1;    end
            default: begin x = av;    y = bv;  cin = 0;    end
        endcase
        full   = x + y + cin;
        lo     = (x % 16) + (y % 16) + cin;
        c_full = (full > 255);
        c_lo   = (lo > 15);
        sfull  = sgn(x, 8) + sgn(y, 8) + cin;
        slo    = sgn(x % 16, 4) + sgn(y % 16, 4) + cin;
        v_full = (sfull > 127) || (sfull < -128);
        v_lo   = (slo > 7) || (slo < -8);
        #2;
        rtag = (o == 3'd6) ? "R6 result" :
               (o >= 3'd2 && o <= 3'd5) ? "R5 result" : "R1 result";
        chk(rtag, 64'(res), 64'(full % 256));
        if (sw) begin
            {m_so, m_ov, m_ov32, m_ca, m_ca32} = sd;
        end else if (w) begin
            if (cen && o != 3'd6) begin
                m_ca   = md ? c_full : c_lo;
                m_ca32 = c_lo;
            end
            if (oen) begin
                vsel   = md ? v_full : v_lo;
                m_ov   = vsel;
                m_ov32 = (o == 3'd6) ? vsel : v_lo;
                m_so   = m_so | vsel;
            end
        end
        @(negedge clk);
        chk(sw ? "R7 flags" : (o == 3'd6 ? "R9 ca" : "R2 ca"), 64'(ca), 64'(m_ca));
        chk(sw ? "R7 flags" : "R2 ca32", 64'(ca32), 64'(m_ca32));
        chk(sw ? "R7 flags" : "R3 ov", 64'(ov), 64'(m_ov));
        chk(sw ? "R7 flags" : "R3 ov32", 64'(ov32), 64'(m_ov32));
        chk(sw ? "R7 flags" : "R4 so", 64'(so), 64'(m_so));
    endtask

    // one vector on the full-width instance with explicit expectations
    task automatic wstep(string tag, input logic [2:0] o, input logic [WW-1:0] av,
                         input logic [WW-1:0] bv, input bit md, input bit oen,
                         input bit cen, input bit sw, input logic [4:0] sd,
                         input logic [WW-1:0] exp_res, input logic [4:0] exp_fl);
        w_op = o; w_a = av; w_b = bv; w_mode = md; w_oe = oen; w_caen = cen;
        w_wr = 1'b1; w_srwr = sw; w_srdata = sd;
        #2;
        chk({tag, " result"}, w_res, exp_res);
        @(negedge clk);
        chk({tag, " flags"}, 64'({w_so, w_ov, w_ov32, w_ca, w_ca32}), 64'(exp_fl));
        w_wr = 1'b0; w_srwr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R8 reset flags", 64'({so, ov, ov32, ca, ca32}), 64'd0);
        chk("R8 reset flags wide", 64'({w_so, w_ov, w_ov32, w_ca, w_ca32}), 64'd0);

        // full-width directed cases (flag order SO,OV,OV32,CA,CA32)
        wstep("R2 full carry",  3'd0, '1, 64'd1, 1, 0, 1, 0, 5'd0, '0, 5'b00011);
        wstep("R2 low carry m64", 3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 1, 0, 1, 0, 5'd0,
              64'h0000_0001_0000_0000, 5'b00001);
        wstep("R2 low carry m32", 3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 1, 0, 5'd0,
              64'h0000_0001_0000_0000, 5'b00011);
        wstep("R6 neg m64", 3'd6, 64'h8000_0000_0000_0000, '0, 1, 1, 1, 0, 5'd0,
              64'h8000_0000_0000_0000, 5'b11111);
        wstep("R7 clear", 3'd0, '0, '0, 1, 1, 1, 1, 5'd0, '0, 5'b00000);
        wstep("R6 neg m32 upper ignored", 3'd6, 64'h1234_5678_8000_0000, '0, 0, 1, 1, 0,
              5'd0, 64'hEDCB_A987_8000_0000, 5'b11100);
        wstep("R7 clear", 3'd0, '0, '0, 1, 0, 0, 1, 5'd0, '0, 5'b00000);
        wstep("R6 neg m64 low-word value", 3'd6, 64'h0000_0000_8000_0000, '0, 1, 1, 1, 0,
              5'd0, 64'hFFFF_FFFF_8000_0000, 5'b00000);
        wstep("R3 ov m64 only full", 3'd0, 64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0000,
              1, 1, 0, 0, 5'd0, 64'h8000_0000_0000_0000, 5'b11000);
        wstep("R4 so sticky", 3'd0, 64'd1, 64'd1, 1, 1, 0, 0, 5'd0, 64'd2, 5'b10000);
        wstep("R5 extended carry-in", 3'd2, 64'd5, 64'd6, 1, 0, 1, 0, 5'd0, 64'd11, 5'b10000);
        wstep("R7 load", 3'd0, '0, '0, 1, 0, 0, 1, 5'b00010, '0, 5'b00010);
        wstep("R5 add-zero uses CA", 3'd5, 64'd41, 64'd99, 1, 0, 1, 0, 5'd0, 64'd42, 5'b00000);

        // directed collision on the small instance: overflow add with a zero load
        step(3'd0, 8'h7F, 8'h01, 1, 1, 1, 1, 0, 5'd0);
        step(3'd0, 8'h7F, 8'h01, 1, 1, 1, 1, 1, 5'd0);
        step(3'd0, 8'h00, 8'h00, 1, 0, 0, 0, 0, 5'd0);
        // R8: idle cycle after an overflow keeps everything
        step(3'd6, 8'h80, 8'h00, 1, 1, 1, 1, 0, 5'd0);
        step(3'd1, 8'h33, 8'h77, 0, 1, 1, 0, 0, 5'd0);
        // R6 half mode: upper nibble ignored
        step(3'd6, 8'h58, 8'h00, 0, 1, 1, 1, 0, 5'd0);

        // near-exhaustive sweep of the small instance
        for (int o = 0; o < 8; o++) begin
            for (int av = 0; av < 256; av++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    int bv;
                    bit sw;
                    bv = ((bi * 17) ^ (av * 3)) % 256;
                    sw = (bi == 9) && av[4];
                    step(3'(o), av, bv, bi[0] ^ av[3], ~av[1] | bi[2],
                         bi[1] | av[0], av[2:0] != 3'd5, sw,
                         5'(av[4:0] ^ {bi[3:0], 1'b0}));
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule